// File: doc/BRIEF.md
# Segmented dynamic element matching encoder

This block sits in front of a bank of 1-bit current DAC elements with mixed weights. Each clock it takes an unsigned (offset-binary) 10-bit code. It turns the code into on/off controls for 32 unit elements of weight 32 and for five element pairs of weights 16, 8, 4, 2 and 1. Each element is driven by one control.

The five low code bits are handled one weight at a time. When a bit is set, exactly one element of that weight's pair is switched on. A pseudo-random ±1 sequence, one per weight, chooses which of the two it is. The five high bits form a count. That count is passed down a five-level binary tree of switching blocks whose leaves are the unit elements. A block that receives an odd value sends the extra unit to one child or the other, following its level's ±1 sequence. A block that receives an even value splits it evenly. Every layer has its own 15-bit LFSR. All the LFSRs step once per clock.

Because the choice of elements keeps changing, mismatch between elements turns into noise that is not correlated with the signal, rather than into harmonic distortion. The element controls are registered, so they appear one clock after the code.

Top module: `sdem_encoder`

## Requirements
- R1: While rst_ni is low, every element control (unit_o, pair_a_o, pair_b_o) is 0, whatever code_i is.
- R2: The controls seen after a rising clock edge encode the code_i sampled at that edge. The latency is exactly one clock.
- R3: The selected weight, 32·(number of ones in unit_o) plus the sum over j of 2^j·(pair_a_o[j] + pair_b_o[j]), equals the code.
- R4: For j = 0..4, pair j has weight 2^j. Exactly one of pair_a_o[j] and pair_b_o[j] is 1 when bit j of the code is 1, and both are 0 when bit j is 0.
- R5: The number of ones in unit_o equals code bits [9:5].
- R6: The unit elements are the tree leaves in index order. At every tree node, the counts of ones in the two contiguous halves of that node's index range differ by at most 1.
- R7: Over repeated codes with bit j set, both pair_a_o[j] and pair_b_o[j] are selected at some time.
- R8: With code bits [9:5] held at 1, the single lit unit element visits at least 8 different indices over 300 cycles.
- R9: Code 0 gives all controls 0. Code 1023 gives 31 unit elements on, with exactly one element of every pair on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 10 | Unsigned DAC code |
| unit_o | output | 32 | Controls of the weight-32 unit elements |
| pair_a_o | output | 5 | First element of each binary pair, bit j has weight 2^j |
| pair_b_o | output | 5 | Second element of each binary pair, bit j has weight 2^j |

## Verification
Every control is due exactly one clock after its code. The bench drives a new code just after each falling edge. One nanosecond later it compares the outputs with the code it drove one period earlier. This catches a combinational path as well as an extra register stage. The randomization results (R7, R8) are tallied over long stretches of cycles and judged once each stretch ends. The reset results are sampled while reset is still held, with a full-scale code on the input.

// File: rtl/sdem_pkg.sv
package sdem_pkg;
  localparam int LFSR_W = 15;

  // distinct, never-zero start state per layer
  function automatic logic [LFSR_W-1:0] seed_for(input int k);
    return LFSR_W'(((k + 1) * 4093) ^ 32'h2b6d) | LFSR_W'(1);
  endfunction
endpackage

// File: rtl/sdem_lfsr.sv
module sdem_lfsr #(
  parameter int W = 15,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic dir_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[W-2:0], q[W-1] ^ q[W-2]};
  end

  assign dir_o = q[0];
endmodule

// File: rtl/sdem_split.sv
// switching block: odd residue goes to hi when dir=+1, to lo when dir=-1
module sdem_split #(
  parameter int W = 5
) (
  input  logic [W-1:0] x_i,
  input  logic         dir_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] half;

  assign half = x_i >> 1;
  assign hi_o = half + W'(x_i[0] & dir_i);
  assign lo_o = half + W'(x_i[0] & ~dir_i);
endmodule

// File: rtl/sdem_tree.sv
module sdem_tree #(
  parameter int DEPTH = 5,
  parameter int VW    = 5
) (
  input  logic [VW-1:0]       root_i,
  input  logic [DEPTH-1:0]    dir_i,
  output logic [2**DEPTH-1:0] leaf_o
);
  localparam int INNER = 2**DEPTH - 1;
  localparam int NODES = 2**(DEPTH+1) - 1;

  logic [VW-1:0] val [NODES];

  assign val[0] = root_i;

  // heap order: node i feeds 2i+1 and 2i+2
  for (genvar i = 0; i < INNER; i++) begin : g_node
    localparam int LVL = $clog2(i + 2) - 1;
    sdem_split #(.W(VW)) i_split (
      .x_i  (val[i]),
      .dir_i(dir_i[LVL]),
      .hi_o (val[2*i+1]),
      .lo_o (val[2*i+2])
    );
  end

  for (genvar k = 0; k < 2**DEPTH; k++) begin : g_leaf
    assign leaf_o[k] = (val[INNER+k] != '0);
  end
endmodule

// File: rtl/sdem_encoder.sv
module sdem_encoder
  import sdem_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int LSB_SEG = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CODE_W-1:0]             code_i,
  output logic [2**(CODE_W-LSB_SEG)-1:0] unit_o,
  output logic [LSB_SEG-1:0]            pair_a_o,
  output logic [LSB_SEG-1:0]            pair_b_o
);
  localparam int MSB_BITS = CODE_W - LSB_SEG;
  localparam int N_UNIT   = 2**MSB_BITS;
  localparam int N_LAYER  = LSB_SEG + MSB_BITS;

  logic [N_LAYER-1:0] dir;
  logic [LSB_SEG-1:0] pa_d, pb_d;
  logic [N_UNIT-1:0]  unit_d;

  for (genvar k = 0; k < N_LAYER; k++) begin : g_seq
    sdem_lfsr #(.W(LFSR_W), .SEED(seed_for(k))) i_lfsr (
      .clk_i,
      .rst_ni,
      .dir_o(dir[k])
    );
  end

  // binary segment: one element of the pair per set bit
  for (genvar j = 0; j < LSB_SEG; j++) begin : g_pair
    assign pa_d[j] = code_i[j] &  dir[j];
    assign pb_d[j] = code_i[j] & ~dir[j];
  end

  // unit segment
  sdem_tree #(.DEPTH(MSB_BITS), .VW(MSB_BITS)) i_tree (
    .root_i(code_i[CODE_W-1:LSB_SEG]),
    .dir_i (dir[N_LAYER-1:LSB_SEG]),
    .leaf_o(unit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_o   <= '0;
      pair_a_o <= '0;
      pair_b_o <= '0;
    end else begin
      unit_o   <= unit_d;
      pair_a_o <= pa_d;
      pair_b_o <= pb_d;
    end
  end
endmodule

// File: rtl/sdem_encoder_chk.sv
module sdem_encoder_chk #(
  parameter int CODE_W  = 10,
  parameter int LSB_SEG = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [CODE_W-1:0]              code_i,
  input logic [2**(CODE_W-LSB_SEG)-1:0] unit_o,
  input logic [LSB_SEG-1:0]             pair_a_o,
  input logic [LSB_SEG-1:0]             pair_b_o
);
  localparam int N_UNIT = 2**(CODE_W-LSB_SEG);
  localparam int HALF   = N_UNIT / 2;

  logic past_ok;
  int   wsum, cnt_l, cnt_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    wsum = $countones(unit_o) << LSB_SEG;
    for (int j = 0; j < LSB_SEG; j++)
      wsum += (int'(pair_a_o[j]) + int'(pair_b_o[j])) << j;
    cnt_l = $countones(unit_o[HALF-1:0]);
    cnt_h = $countones(unit_o[N_UNIT-1:HALF]);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (unit_o == '0 && pair_a_o == '0 && pair_b_o == '0));

  // R3
  weight_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> wsum == int'($past(code_i)));

  // R4
  pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_a_o & pair_b_o) == '0);

  // R5
  unit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> $countones(unit_o) == int'($past(code_i) >> LSB_SEG));

  // R6
  root_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_l - cnt_h <= 1) && (cnt_h - cnt_l <= 1));
endmodule

bind sdem_encoder sdem_encoder_chk #(.CODE_W(CODE_W), .LSB_SEG(LSB_SEG)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .code_i  (code_i),
  .unit_o  (unit_o),
  .pair_a_o(pair_a_o),
  .pair_b_o(pair_b_o)
);

// File: tb/test_sdem_encoder.sv
`timescale 1ns/1ps
module test_sdem_encoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [9:0]  code_i = '0;
  logic [31:0] unit_o;
  logic [4:0]  pair_a_o, pair_b_o;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [9:0] prev = '0;
  int seen_a [5];
  int seen_b [5];
  logic [31:0] pos_seen = '0;

  sdem_encoder i_sdem_encoder (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [31:0] v, input int lo, input int n);
    int c = 0;
    for (int i = lo; i < lo + n; i++) c += int'(v[i]);
    return c;
  endfunction

  // outputs must encode prev (code driven one period earlier)
  task automatic check_prev();
    int sum, worst;
    sum = popc(unit_o, 0, 32) * 32;
    for (int j = 0; j < 5; j++) sum += (int'(pair_a_o[j]) + int'(pair_b_o[j])) << j;
    chk(sum == int'(prev), "R2/R3 weighted sum", sum, int'(prev));
    chk(popc(unit_o, 0, 32) == int'(prev[9:5]), "R5 unit count",
        popc(unit_o, 0, 32), int'(prev[9:5]));
    for (int j = 0; j < 5; j++) begin
      chk((int'(pair_a_o[j]) + int'(pair_b_o[j])) == int'(prev[j]), "R4 pair select",
          int'(pair_a_o[j]) + int'(pair_b_o[j]), int'(prev[j]));
      if (prev[j] && pair_a_o[j]) seen_a[j]++;
      if (prev[j] && pair_b_o[j]) seen_b[j]++;
    end
    worst = 0;
    for (int l = 0; l < 5; l++) begin
      int sz = 32 >> l;
      for (int n = 0; n < (1 << l); n++) begin
        int d = popc(unit_o, n*sz, sz/2) - popc(unit_o, n*sz + sz/2, sz/2);
        if (d < 0) d = -d;
        if (d > worst) worst = d;
      end
    end
    chk(worst <= 1, "R6 tree balance", worst, 1);
    if (prev[9:5] == 5'd1) pos_seen |= unit_o;
  endtask

  task automatic step(input logic [9:0] c);
    code_i = c;
    #1;
    check_prev();
    prev = c;
    @(negedge clk_i);
  endtask

  initial begin
    int npos;
    #1 rst_ni = 1'b0;
    code_i = 10'd1023;
    repeat (3) @(negedge clk_i);
    #1;
    // R1: held in reset with full-scale code
    chk(unit_o == '0 && pair_a_o == '0 && pair_b_o == '0, "R1 reset clear",
        popc(unit_o, 0, 32) + int'(pair_a_o) + int'(pair_b_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev = '0;

    // R9 extremes
    step(10'd0);
    step(10'd1023);
    step(10'd0);
    chk(unit_o == '0 && pair_a_o == '0 && pair_b_o == '0, "R9 zero code",
        int'(pair_a_o) + int'(pair_b_o), 0);
    step(10'd1023);
    step(10'd1023);
    chk(popc(unit_o, 0, 32) == 31 && (pair_a_o ^ pair_b_o) == 5'h1f, "R9 full scale",
        popc(unit_o, 0, 32), 31);

    // walking ones and alternating codes
    for (int b = 0; b < 10; b++) step(10'(1 << b));
    for (int i = 0; i < 40; i++) step(i[0] ? 10'h2aa : 10'h155);

    // random codes
    for (int i = 0; i < 1500; i++) step(10'($urandom));

    // R8: one unit element at a time
    for (int i = 0; i < 300; i++) step({5'd1, 5'($urandom)});
    step(10'd0);
    npos = popc(pos_seen, 0, 32);
    chk(npos >= 8, "R8 unit spread", npos, 8);

    // R7: both pair members used
    for (int j = 0; j < 5; j++)
      chk(seen_a[j] > 0 && seen_b[j] > 0, "R7 pair spread",
          (seen_a[j] < seen_b[j]) ? seen_a[j] : seen_b[j], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule